// File: doc/BRIEF.md
# Shared Bus Ownership Handshake Controller

This block sits beside one master on a bus that several masters share. When local logic has transfers to make, the block raises a bus request and waits for the external arbiter's grant. Holding the grant is not enough to take the bus. The block also waits until it sees the shared active-low busy line high, which shows that the previous owner has let go. Only then does it pull busy low and enable its master-only drivers. All handshake outputs change on the bus clock.

After the last transfer, the owner can stay parked on the bus. It keeps busy low and its drivers enabled, so a later local request resumes transfers at once, without a new request to the arbiter. When the arbiter withdraws the grant, the block releases busy in two steps. It drives the line high for one cycle and then stops driving, so that an external pull-up holds the line high. A run-time mode input chooses how the grant and busy inputs are taken. In one setting each input passes through its own two-flop synchronizer. In the other setting the inputs are used directly, and the system must meet setup and hold at the bus clock.

Top module: `bus_own_ctrl`

## Requirements
- R1: Out of reset, bus_req_o, busy_oe_o, mst_oe_o and xfer_go_o are all 0, and busy_n_o is 1.
- R2: A local request raises bus_req_o one cycle later. bus_req_o stays 1 until ownership is taken, or drops one cycle after the local request is withdrawn before a grant is seen.
- R3: Ownership begins only after a cycle in which the grant is seen high and busy is seen high (free). While busy is seen low, the block never claims the bus, even when it holds the grant.
- R4: While the block owns the bus, it drives busy low (busy_oe_o=1, busy_n_o=0) and holds mst_oe_o=1. xfer_go_o=1 only in active ownership.
- R5: A transfer-done pulse while the local request is low moves an active owner that still holds the grant into parking. In parking, busy stays driven low and xfer_go_o=0. A done pulse while the request is still high keeps the block active. Parking holds for as long as the grant stays and no request arrives.
- R6: A local request while parked returns the block to active ownership on the next cycle, and bus_req_o stays 0 throughout.
- R7: When a parked owner sees the grant removed, it drives busy high for exactly one cycle (busy_oe_o=1, busy_n_o=1, mst_oe_o=0). After that cycle all outputs are disabled.
- R8: A grant removed during active ownership does not cut transfers short. On the final done pulse the block goes straight to the one-cycle drive-high release.
- R9: With sync_en_i=1, grant and busy take effect two clock edges later than with sync_en_i=0, where they act on the next edge.
- R10: Two such blocks sharing one busy line and one arbiter never both hold mst_oe_o, and never both drive busy low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sync_en_i | input | 1 | 1: grant and busy pass through two-flop synchronizers |
| xfer_req_i | input | 1 | Local logic has transfers pending |
| xfer_done_i | input | 1 | One-cycle pulse: current transfer finished |
| xfer_go_o | output | 1 | Local logic may run transfers (active ownership) |
| bus_gnt_i | input | 1 | Grant from the external arbiter, active high |
| bus_req_o | output | 1 | Request to the external arbiter, active high |
| busy_n_i | input | 1 | Shared busy line as seen on the bus, 0 = busy |
| busy_n_o | output | 1 | Value driven onto the busy line when enabled |
| busy_oe_o | output | 1 | Output enable for the busy line driver |
| mst_oe_o | output | 1 | Enable for the master-only bus drivers |

## Verification
Every cycle, the embedded assertions check these rules. A claim requires a grant and a free busy line on the previous edge. Busy leaves the driven-low state only through a single drive-high cycle, which is followed by tri-state. No bus request is raised while the block owns the bus. xfer_go_o implies the bus is owned. The bench compares one master against a behavioural model on every clock, across both synchronizer settings. It also checks the mutual exclusion between two masters on a single pulled-up line. Only its scenarios can show three behaviours. These are the exact claim latency when an external device holds busy low, the handover from a parked owner to a waiting master, and the way a revoked active owner finishes its transfers before it releases the bus.

// File: rtl/bus_own_pkg.sv
package bus_own_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT_FREE,
    ST_OWN_ACT,
    ST_OWN_PARK,
    ST_REL_HIGH
  } own_state_e;
endpackage

// File: rtl/own_in_sync.sv
module own_in_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else if (STAGES == 1) chain_q <= d_i;
        else chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = en_i ? chain_q[STAGES-1] : d_i;
    end
  endgenerate
endmodule

// File: rtl/own_fsm.sv
module own_fsm
  import bus_own_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       gnt_s_i,
  input  logic       busy_n_s_i,
  input  logic       xfer_req_i,
  input  logic       xfer_done_i,
  output own_state_e state_o
);
  own_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:      if (xfer_req_i) st_d = ST_REQ;
      ST_REQ: begin
        if (!xfer_req_i)  st_d = ST_IDLE;
        else if (gnt_s_i) st_d = ST_WAIT_FREE;
      end
      ST_WAIT_FREE: begin
        if (!gnt_s_i)        st_d = ST_REQ;
        else if (busy_n_s_i) st_d = ST_OWN_ACT;
      end
      ST_OWN_ACT:
        if (xfer_done_i && !xfer_req_i) st_d = gnt_s_i ? ST_OWN_PARK : ST_REL_HIGH;
      ST_OWN_PARK: begin
        if (!gnt_s_i)        st_d = ST_REL_HIGH;
        else if (xfer_req_i) st_d = ST_OWN_ACT;
      end
      ST_REL_HIGH:  st_d = ST_IDLE;
      default:      st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;

  logic own_w;
  assign own_w = (st_q == ST_OWN_ACT) || (st_q == ST_OWN_PARK);

  AST_CLAIM_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_w && !$past(own_w)) |-> ($past(gnt_s_i) && $past(busy_n_s_i))) else $error("claim on busy"); // R3
  AST_PARK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OWN_PARK && gnt_s_i && !xfer_req_i) |=> (st_q == ST_OWN_PARK)) else $error("park lost"); // R5
  AST_PARK_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OWN_PARK && gnt_s_i && xfer_req_i) |=> (st_q == ST_OWN_ACT)) else $error("no resume"); // R6
endmodule

// File: rtl/own_out_dec.sv
module own_out_dec
  import bus_own_pkg::*;
(
  input  own_state_e state_i,
  output logic       bus_req_o,
  output logic       busy_oe_o,
  output logic       busy_n_o,
  output logic       mst_oe_o,
  output logic       xfer_go_o
);
  always_comb begin
    bus_req_o = 1'b0;
    busy_oe_o = 1'b0;
    busy_n_o  = 1'b1;
    mst_oe_o  = 1'b0;
    xfer_go_o = 1'b0;
    unique case (state_i)
      ST_REQ, ST_WAIT_FREE: bus_req_o = 1'b1;
      ST_OWN_ACT: begin
        busy_oe_o = 1'b1;
        busy_n_o  = 1'b0;
        mst_oe_o  = 1'b1;
        xfer_go_o = 1'b1;
      end
      ST_OWN_PARK: begin
        busy_oe_o = 1'b1;
        busy_n_o  = 1'b0;
        mst_oe_o  = 1'b1;
      end
      ST_REL_HIGH: busy_oe_o = 1'b1;  // active pull-up cycle
      default: ;
    endcase
  end
endmodule

// File: rtl/bus_own_ctrl.sv
module bus_own_ctrl
  import bus_own_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_en_i,
  input  logic xfer_req_i,
  input  logic xfer_done_i,
  output logic xfer_go_o,
  input  logic bus_gnt_i,
  output logic bus_req_o,
  input  logic busy_n_i,
  output logic busy_n_o,
  output logic busy_oe_o,
  output logic mst_oe_o
);
  logic       gnt_s, busy_n_s;
  own_state_e state;

  own_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_gnt_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sync_en_i), .d_i(bus_gnt_i), .q_o(gnt_s)
  );
  // busy idles high through the pull-up
  own_in_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_busy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(sync_en_i), .d_i(busy_n_i), .q_o(busy_n_s)
  );

  own_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .gnt_s_i(gnt_s), .busy_n_s_i(busy_n_s),
    .xfer_req_i(xfer_req_i), .xfer_done_i(xfer_done_i), .state_o(state)
  );

  own_out_dec u_dec (
    .state_i(state), .bus_req_o(bus_req_o), .busy_oe_o(busy_oe_o),
    .busy_n_o(busy_n_o), .mst_oe_o(mst_oe_o), .xfer_go_o(xfer_go_o)
  );

  logic drive_low;
  assign drive_low = busy_oe_o && !busy_n_o;

  AST_RELEASE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_low) |-> (busy_oe_o && busy_n_o)) else $error("no pull-up cycle"); // R7
  AST_RELEASE_TRISTATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_oe_o && busy_n_o) |=> !busy_oe_o) else $error("no tri-state"); // R7
  AST_NO_REQ_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_oe_o |-> !bus_req_o) else $error("request while owner"); // R6
  AST_GO_OWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_go_o |-> (drive_low && mst_oe_o)) else $error("go without ownership"); // R4
endmodule

// File: tb/tb_bus_own_ctrl.sv
`timescale 1ns/1ps
module tb_bus_own_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  int n_run = 0, n_fail = 0;
  bit done_flag = 1'b0;

  logic a_sync = 1'b0, a_req = 1'b0, a_done = 1'b0;
  logic b_req = 1'b0, b_done = 1'b0, ext_low = 1'b0;
  logic a_go, a_breq, a_bn, a_oe, a_moe;
  logic b_go, b_breq, b_bn, b_oe, b_moe;
  logic gnt_a, gnt_b, busy_line;

  // shared line with pull-up
  assign busy_line = ~((a_oe & ~a_bn) | (b_oe & ~b_bn) | ext_low);

  // arbiter: automatic or manual
  logic arb_en = 1'b1, man_ga = 1'b0, man_gb = 1'b0;
  logic arb_ga = 1'b0, arb_gb = 1'b0;
  int   holder = 0, gap = 0;
  assign gnt_a = arb_en ? arb_ga : man_ga;
  assign gnt_b = arb_en ? arb_gb : man_gb;

  always @(negedge clk) begin
    if (arb_en && rst_n) begin
      if (holder == 0) begin
        if (gap > 0) gap--;
        else if (busy_line) begin
          if (a_breq) begin arb_ga = 1'b1; holder = 1; end
          else if (b_breq) begin arb_gb = 1'b1; holder = 2; end
        end
      end else if (holder == 1 && b_breq) begin
        arb_ga = 1'b0; holder = 0; gap = 4;
      end else if (holder == 2 && a_breq) begin
        arb_gb = 1'b0; holder = 0; gap = 4;
      end
    end
  end

  bus_own_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .sync_en_i(a_sync), .xfer_req_i(a_req),
    .xfer_done_i(a_done), .xfer_go_o(a_go), .bus_gnt_i(gnt_a), .bus_req_o(a_breq),
    .busy_n_i(busy_line), .busy_n_o(a_bn), .busy_oe_o(a_oe), .mst_oe_o(a_moe)
  );
  bus_own_ctrl dut_b (
    .clk_i(clk), .rst_ni(rst_n), .sync_en_i(1'b0), .xfer_req_i(b_req),
    .xfer_done_i(b_done), .xfer_go_o(b_go), .bus_gnt_i(gnt_b), .bus_req_o(b_breq),
    .busy_n_i(busy_line), .busy_n_o(b_bn), .busy_oe_o(b_oe), .mst_oe_o(b_moe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference of master A: phase 0 idle,1 asking,2 granted/waiting,
  // 3 active,4 parked,5 pull-up cycle
  int m_ph = 0;
  bit g_d1 = 0, g_d2 = 0, b_d1 = 1, b_d2 = 1;
  bit c_g = 0, c_b = 1, c_req = 0, c_done = 0, c_sync = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; g_d1 = 0; g_d2 = 0; b_d1 = 1; b_d2 = 1;
    end else begin
      bit g, b;
      g = c_sync ? g_d2 : c_g;  // R9: two-edge lag when synchronized
      b = c_sync ? b_d2 : c_b;
      g_d2 = g_d1; g_d1 = c_g; b_d2 = b_d1; b_d1 = c_b;
      case (m_ph)
        0: if (c_req) m_ph = 1;
        1: if (!c_req) m_ph = 0; else if (g) m_ph = 2;
        2: if (!g) m_ph = 1; else if (b) m_ph = 3;
        3: if (c_done && !c_req) m_ph = g ? 4 : 5;
        4: if (!g) m_ph = 5; else if (c_req) m_ph = 3;
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    #5;
    if (rst_n && !done_flag) begin
      bit e_req, e_oe, e_bn, e_moe, e_go;
      e_req = (m_ph == 1 || m_ph == 2);
      e_oe  = (m_ph >= 3);
      e_bn  = !(m_ph == 3 || m_ph == 4);
      e_moe = (m_ph == 3 || m_ph == 4);
      e_go  = (m_ph == 3);
      chk(a_breq == e_req, "R2 model bus_req", a_breq, e_req);
      chk(a_oe == e_oe && a_bn == e_bn, "R7 model busy drive", {a_oe, a_bn}, {e_oe, e_bn});
      chk(a_moe == e_moe && a_go == e_go, "R4 model owner outputs", {a_moe, a_go}, {e_moe, e_go});
      chk(!(a_moe && b_moe), "R10 both own", {a_moe, b_moe}, 0);
      chk(!((a_oe && !a_bn) && (b_oe && !b_bn)), "R10 both drive low", {a_oe, b_oe}, 0);
    end
    c_g = gnt_a; c_b = busy_line; c_req = a_req; c_done = a_done; c_sync = a_sync;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_a(input bit want_moe, input int lim, input string tag);
    int k = 0;
    while (a_moe != want_moe && k < lim) begin @(negedge clk); k++; end
    chk(a_moe == want_moe, tag, a_moe, want_moe);
  endtask

  task automatic pulse_a_done;
    @(negedge clk); a_done = 1'b1;
    @(negedge clk); a_done = 1'b0;
  endtask

  task automatic pulse_b_done;
    @(negedge clk); b_done = 1'b1;
    @(negedge clk); b_done = 1'b0;
  endtask

  task automatic report;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    done_flag = 1'b1;
    report();
    $finish;
  end

  initial begin
    cyc(2);
    chk(!a_breq && !a_oe && !a_moe && !a_go && a_bn, "R1 reset outputs", {a_breq, a_oe, a_moe, a_go}, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(!a_breq && !a_oe && !a_moe && !a_go, "R1 idle after reset", {a_breq, a_oe, a_moe}, 0);

    // first ownership, direct sampling
    @(negedge clk); a_req = 1'b1;
    @(negedge clk);
    chk(a_breq, "R2 request raised", a_breq, 1);
    wait_a(1'b1, 20, "R3 A claims free bus");
    chk(a_go && a_oe && !a_bn, "R4 active drives low", {a_go, a_oe, a_bn}, 6);
    pulse_a_done();
    chk(a_go, "R5 done with request high stays active", a_go, 1);
    @(negedge clk); a_req = 1'b0; a_done = 1'b1;
    @(negedge clk); a_done = 1'b0;
    chk(a_moe && !a_go && a_oe && !a_bn, "R5 parked", {a_moe, a_go}, 2);
    cyc(6);
    chk(a_moe && !a_go && !a_breq, "R5 park held", {a_moe, a_go, a_breq}, 4);

    // resume from park
    @(negedge clk); a_req = 1'b1;
    @(negedge clk);
    chk(a_go && !a_breq, "R6 resume without request", {a_go, a_breq}, 2);
    @(negedge clk); a_req = 1'b0; a_done = 1'b1;
    @(negedge clk); a_done = 1'b0;
    chk(a_moe && !a_go, "R5 parked again", {a_moe, a_go}, 2);

    // B asks: A parked must release with pull-up cycle
    @(negedge clk); b_req = 1'b1;
    begin
      int k = 0;
      while (!(a_oe && a_bn) && k < 20) begin @(negedge clk); k++; end
      chk(a_oe && a_bn && !a_moe, "R7 pull-up cycle", {a_oe, a_bn, a_moe}, 6);
      @(negedge clk);
      chk(!a_oe && !a_moe, "R7 tri-state after pull-up", {a_oe, a_moe}, 0);
    end
    begin
      int k = 0;
      while (!b_moe && k < 30) begin @(negedge clk); k++; end
      chk(b_moe && !a_moe, "R10 B owns after handover", {b_moe, a_moe}, 2);
    end
    pulse_b_done();
    @(negedge clk); b_req = 1'b0; b_done = 1'b1;
    @(negedge clk); b_done = 1'b0;

    // A requests while B is parked
    @(negedge clk); a_req = 1'b1;
    wait_a(1'b1, 40, "R3 A claims after B release");
    chk(!b_moe, "R10 B released", b_moe, 0);

    // revoke while A active: transfers continue, then direct release
    @(negedge clk); b_req = 1'b1;
    cyc(8);
    chk(a_go && !gnt_a, "R8 active survives revoke", {a_go, gnt_a}, 2);
    @(negedge clk); a_req = 1'b0; a_done = 1'b1;
    @(negedge clk); a_done = 1'b0;
    chk(a_oe && a_bn && !a_moe, "R8 direct release", {a_oe, a_bn, a_moe}, 6);
    @(negedge clk);
    chk(!a_oe, "R7 released line", a_oe, 0);
    begin
      int k = 0;
      while (!b_moe && k < 30) begin @(negedge clk); k++; end
      chk(b_moe, "R10 B takes bus", b_moe, 1);
    end
    @(negedge clk); b_req = 1'b0; b_done = 1'b1;
    @(negedge clk); b_done = 1'b0;

    // manual arbitration: release B, then external holder on busy
    @(negedge clk); man_ga = 1'b0; man_gb = 1'b0; arb_en = 1'b0;
    cyc(4);
    chk(!b_oe && !b_moe, "R7 B released on manual revoke", {b_oe, b_moe}, 0);

    for (int mode = 0; mode < 2; mode++) begin
      @(negedge clk); a_sync = mode[0]; ext_low = 1'b1;
      cyc(3);
      @(negedge clk); man_ga = 1'b1; a_req = 1'b1;
      cyc(10);
      chk(!a_moe && a_breq, "R3 no claim while busy low", {a_moe, a_breq}, 1);
      @(negedge clk); ext_low = 1'b0;
      if (mode == 0) begin
        @(negedge clk);
        chk(a_moe, "R9 direct claim after one edge", a_moe, 1);
      end else begin
        @(negedge clk);
        chk(!a_moe, "R9 sync no claim edge 1", a_moe, 0);
        @(negedge clk);
        chk(!a_moe, "R9 sync no claim edge 2", a_moe, 0);
        @(negedge clk);
        chk(a_moe, "R9 sync claim edge 3", a_moe, 1);
      end
      @(negedge clk); a_req = 1'b0; a_done = 1'b1;
      @(negedge clk); a_done = 1'b0; man_ga = 1'b0;
      cyc(6);
      chk(!a_oe && !a_moe, "R7 released after mode run", {a_oe, a_moe}, 0);
    end

    // withdrawal before grant
    @(negedge clk); a_sync = 1'b0; a_req = 1'b1;
    @(negedge clk);
    chk(a_breq, "R2 request up", a_breq, 1);
    cyc(3);
    @(negedge clk); a_req = 1'b0;
    @(negedge clk);
    chk(!a_breq && !a_moe, "R2 request withdrawn", {a_breq, a_moe}, 0);

    cyc(4);
    done_flag = 1'b1;
    report();
    $finish;
  end
endmodule